// File: doc/BRIEF.md
# Software (Xon/Xoff) Flow Controller

This block sits beside a serial receiver and decides whether the paired transmitter may send. Every received character is compared with four programmable characters: two that resume transmission and two that stop it. A stop match parks the transmitter until a resume match arrives. Matching can use one character from either of the two sets, or a pair of characters that must arrive back to back. Flow characters that complete a match are consumed rather than passed on to the receive buffer.

A separate special-character detector flags any received byte equal to the second stop character. Such a byte is always passed on. The block raises an interrupt request for stop detections and special detections. It also gates the transmit enable with an active-low clear-to-send input when that option is selected. The configuration and the four characters can be written only while the line-control value presented to the block equals an unlock code (0xBF by default).

Top module: `swfc_ctrl`

## Requirements
- R1: After reset, tx_enable is 1 and xoff_stat, spec_stat and irq are 0. The mode is off, and special detect and CTS gating are disabled.
- R2: A register write (reg_wr=1) takes effect at the clock edge only if lcr_in equals UNLOCK (0xBF); otherwise it changes nothing. reg_sel selects the target: 0 = config, 1 = resume char A, 2 = resume char B, 3 = stop char A, 4 = stop char B.
- R3: Config bits [1:0] select the mode: 00 off, 01 single using set A, 10 single using set B, 11 pair (A then B). In off mode every valid byte is pushed and tx_enable depends only on CTS gating.
- R4: In a single mode, a valid byte equal to the selected stop char clears tx_enable from the next cycle. A byte equal to the selected resume char sets it again. Neither of these bytes is pushed. If a byte matches both, the stop match wins.
- R5: In pair mode, the stop action happens only when stop char A is followed by stop char B in consecutive valid bytes, and the resume action only for resume char A followed by resume char B. Idle cycles between the two bytes do not break the pair. Only the second byte of a matched pair is withheld from rx_push.
- R6: Each stop detection sets xoff_stat, which holds until acknowledged. irq equals rx_int_en AND (xoff_stat OR spec_stat).
- R7: With config bit 5 set, a valid byte equal to stop char B sets spec_stat and is always pushed, even when it also completes a stop match.
- R8: Bit 0 of each character register is compared with bit 0 of rx_byte, so a bit-reversed value does not match.
- R9: With config bit 7 set, tx_enable is 0 whenever cts_n is 1. With bit 7 clear, cts_n has no effect.
- R10: irq_ack clears xoff_stat and spec_stat at the next edge. A detection in the same cycle takes priority and leaves its flag set.
- R11: Writing mode off releases a suspended transmitter: tx_enable is 1 two cycles after the write edge (with no CTS gating).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcr_in | input | LCR_W | Current line-control value; writes are accepted only when it equals UNLOCK |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 config, 1/2 resume A/B, 3/4 stop A/B) |
| reg_wdata | input | DATA_W | Write data |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DATA_W | Received character |
| rx_int_en | input | 1 | Receive interrupt enable |
| irq_ack | input | 1 | Clears the status flags |
| cts_n | input | 1 | Clear-to-send, active low |
| tx_enable | output | 1 | Transmitter may send |
| rx_push | output | 1 | Current valid byte should be written to the receive buffer |
| xoff_stat | output | 1 | Sticky stop-detection flag |
| spec_stat | output | 1 | Sticky special-character flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every byte value through each mode, including a special-detect variant, against an arithmetic model. A comparator that used the wrong character set, or a reversed bit order, would stop or push on the wrong byte. Directed pair sequences check that a reversed or interrupted pair does nothing while idle gaps keep a pair alive; a design keyed to cycles instead of characters would suspend or miss. Other cases cover locked writes that must leave behaviour unchanged, an acknowledge colliding with a new detection, a special byte that also completes a stop match (it must still be pushed), and release of a parked transmitter when the mode is switched off.

// File: rtl/swfc_pkg.sv
`timescale 1ns/1ps
package swfc_pkg;
   typedef enum logic [1:0] {
      FM_OFF  = 2'b00,
      FM_SETA = 2'b01,
      FM_SETB = 2'b10,
      FM_PAIR = 2'b11
   } flow_mode_e;

   typedef enum logic [2:0] {
      SEL_CFG   = 3'd0,
      SEL_RES_A = 3'd1,
      SEL_RES_B = 3'd2,
      SEL_STP_A = 3'd3,
      SEL_STP_B = 3'd4
   } reg_sel_e;

   localparam int NUM_CHARS  = 4;
   localparam int IDX_RES_A  = 0;
   localparam int IDX_RES_B  = 1;
   localparam int IDX_STP_A  = 2;
   localparam int IDX_STP_B  = 3;
   localparam int CFG_SPEC_B = 5;
   localparam int CFG_CTS_B  = 7;
endpackage

// File: rtl/swfc_regs.sv
`timescale 1ns/1ps
module swfc_regs
   import swfc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LCR_W  = 8,
   parameter logic [LCR_W-1:0] UNLOCK = 'hBF
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [LCR_W-1:0]                 lcr_in,
   input  logic                             reg_wr,
   input  logic [2:0]                       reg_sel,
   input  logic [DATA_W-1:0]                reg_wdata,
   output flow_mode_e                       mode,
   output logic                             spec_en,
   output logic                             cts_en,
   output logic [NUM_CHARS-1:0][DATA_W-1:0] chars
);
   logic wr_ok;
   assign wr_ok = reg_wr && (lcr_in == UNLOCK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= FM_OFF;
         spec_en <= 1'b0;
         cts_en  <= 1'b0;
      end else if (wr_ok && reg_sel == SEL_CFG) begin
         mode    <= flow_mode_e'(reg_wdata[1:0]);
         spec_en <= reg_wdata[CFG_SPEC_B];
         cts_en  <= reg_wdata[CFG_CTS_B];
      end
   end

   for (genvar i = 0; i < NUM_CHARS; i++) begin : g_char
      localparam logic [2:0] MY_SEL = 3'(i + 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chars[i] <= '0;
         else if (wr_ok && reg_sel == MY_SEL)
            chars[i] <= reg_wdata;
      end
   end
endmodule

// File: rtl/swfc_match.sv
`timescale 1ns/1ps
module swfc_match
   import swfc_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit PAIR_EN = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             rx_valid,
   input  logic [DATA_W-1:0]                rx_byte,
   input  flow_mode_e                       mode,
   input  logic [NUM_CHARS-1:0][DATA_W-1:0] chars,
   output logic                             res_hit,
   output logic                             stp_hit,
   output logic                             eq_stp_b
);
   logic [NUM_CHARS-1:0] eq;

   for (genvar i = 0; i < NUM_CHARS; i++) begin : g_cmp
      assign eq[i] = (rx_byte == chars[i]);
   end

   assign eq_stp_b = eq[IDX_STP_B];

   logic pend_res, pend_stp;

   if (PAIR_EN) begin : g_pair
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_res <= 1'b0;
            pend_stp <= 1'b0;
         end else if (mode != FM_PAIR) begin
            pend_res <= 1'b0;
            pend_stp <= 1'b0;
         end else if (rx_valid) begin
            pend_res <= eq[IDX_RES_A];
            pend_stp <= eq[IDX_STP_A];
         end
      end
   end else begin : g_nopair
      assign pend_res = 1'b0;
      assign pend_stp = 1'b0;
   end

   always_comb begin
      res_hit = 1'b0;
      stp_hit = 1'b0;
      unique case (mode)
         FM_SETA: begin
            res_hit = eq[IDX_RES_A];
            stp_hit = eq[IDX_STP_A];
         end
         FM_SETB: begin
            res_hit = eq[IDX_RES_B];
            stp_hit = eq[IDX_STP_B];
         end
         FM_PAIR: begin
            res_hit = pend_res && eq[IDX_RES_B];
            stp_hit = pend_stp && eq[IDX_STP_B];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/swfc_gate.sv
`timescale 1ns/1ps
module swfc_gate
   import swfc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_valid,
   input  flow_mode_e mode,
   input  logic       spec_en,
   input  logic       cts_en,
   input  logic       cts_n,
   input  logic       rx_int_en,
   input  logic       irq_ack,
   input  logic       res_hit,
   input  logic       stp_hit,
   input  logic       eq_stp_b,
   output logic       tx_enable,
   output logic       rx_push,
   output logic       xoff_stat,
   output logic       spec_stat,
   output logic       irq
);
   logic parked, spec_now, stp_now, res_now;

   assign spec_now = rx_valid && spec_en && eq_stp_b;
   assign stp_now  = rx_valid && stp_hit;
   assign res_now  = rx_valid && res_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         parked <= 1'b0;
      else if (mode == FM_OFF)
         parked <= 1'b0;
      else if (stp_now)
         parked <= 1'b1;
      else if (res_now)
         parked <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xoff_stat <= 1'b0;
         spec_stat <= 1'b0;
      end else begin
         if (stp_now)      xoff_stat <= 1'b1;
         else if (irq_ack) xoff_stat <= 1'b0;
         if (spec_now)     spec_stat <= 1'b1;
         else if (irq_ack) spec_stat <= 1'b0;
      end
   end

   assign rx_push   = rx_valid && (!(stp_hit || res_hit) || spec_now);
   assign tx_enable = !parked && !(cts_en && cts_n);
   assign irq       = rx_int_en && (xoff_stat || spec_stat);
endmodule

// File: rtl/swfc_ctrl.sv
`timescale 1ns/1ps
module swfc_ctrl
   import swfc_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int LCR_W   = 8,
   parameter logic [LCR_W-1:0] UNLOCK = 'hBF,
   parameter bit PAIR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LCR_W-1:0]  lcr_in,
   input  logic              reg_wr,
   input  logic [2:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_int_en,
   input  logic              irq_ack,
   input  logic              cts_n,
   output logic              tx_enable,
   output logic              rx_push,
   output logic              xoff_stat,
   output logic              spec_stat,
   output logic              irq
);
   if (DATA_W < 8 || DATA_W > 16) begin : g_bad_data_w
      $error("swfc_ctrl: DATA_W must be 8..16");
   end
   if (LCR_W < 1) begin : g_bad_lcr_w
      $error("swfc_ctrl: LCR_W must be positive");
   end

   flow_mode_e                       mode_q;
   logic                             spec_en_q, cts_en_q;
   logic [NUM_CHARS-1:0][DATA_W-1:0] chars_q;
   logic                             res_hit, stp_hit, eq_stp_b;

   swfc_regs #(.DATA_W(DATA_W), .LCR_W(LCR_W), .UNLOCK(UNLOCK)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .lcr_in    (lcr_in),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .mode      (mode_q),
      .spec_en   (spec_en_q),
      .cts_en    (cts_en_q),
      .chars     (chars_q)
   );

   swfc_match #(.DATA_W(DATA_W), .PAIR_EN(PAIR_EN)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .mode     (mode_q),
      .chars    (chars_q),
      .res_hit  (res_hit),
      .stp_hit  (stp_hit),
      .eq_stp_b (eq_stp_b)
   );

   swfc_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .mode      (mode_q),
      .spec_en   (spec_en_q),
      .cts_en    (cts_en_q),
      .cts_n     (cts_n),
      .rx_int_en (rx_int_en),
      .irq_ack   (irq_ack),
      .res_hit   (res_hit),
      .stp_hit   (stp_hit),
      .eq_stp_b  (eq_stp_b),
      .tx_enable (tx_enable),
      .rx_push   (rx_push),
      .xoff_stat (xoff_stat),
      .spec_stat (spec_stat),
      .irq       (irq)
   );
endmodule

// File: rtl/swfc_chk.sv
`timescale 1ns/1ps
module swfc_chk #(
   parameter int LCR_W = 8,
   parameter logic [LCR_W-1:0] UNLOCK = 'hBF
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LCR_W-1:0] lcr_in,
   input logic             reg_wr,
   input logic             rx_valid,
   input logic             irq_ack,
   input logic             cts_n,
   input logic [1:0]       mode,
   input logic             spec_en,
   input logic             cts_en,
   input logic             tx_enable,
   input logic             xoff_stat,
   input logic             spec_stat
);
   AST_LOCK_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && lcr_in != UNLOCK) |=> $stable({mode, spec_en, cts_en})); // R2
   AST_OFF_MODE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && $past(mode) == 2'b00 && !cts_en) |-> tx_enable); // R3
   AST_XOFF_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xoff_stat) |-> $past(rx_valid)); // R6
   AST_SPEC_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spec_stat) |-> $past(rx_valid && spec_en)); // R7
   AST_CTS_HOLDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_en && cts_n) |-> !tx_enable); // R9
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !rx_valid) |=> (!xoff_stat && !spec_stat)); // R10
endmodule

bind swfc_ctrl swfc_chk #(.LCR_W(LCR_W), .UNLOCK(UNLOCK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lcr_in    (lcr_in),
   .reg_wr    (reg_wr),
   .rx_valid  (rx_valid),
   .irq_ack   (irq_ack),
   .cts_n     (cts_n),
   .mode      (mode_q),
   .spec_en   (spec_en_q),
   .cts_en    (cts_en_q),
   .tx_enable (tx_enable),
   .xoff_stat (xoff_stat),
   .spec_stat (spec_stat)
);

// File: tb/swfc_ctrl_bench.sv
`timescale 1ns/1ps
module swfc_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] lcr_in = 8'h00;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_sel = 3'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       rx_int_en = 1'b1;
   logic       irq_ack = 1'b0;
   logic       cts_n = 1'b0;
   logic       tx_enable, rx_push, xoff_stat, spec_stat, irq;

   always #2.5 clk = ~clk;

   swfc_ctrl u_swfc_ctrl (
      .clk(clk), .rst_n(rst_n), .lcr_in(lcr_in), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .rx_int_en(rx_int_en), .irq_ack(irq_ack),
      .cts_n(cts_n), .tx_enable(tx_enable), .rx_push(rx_push),
      .xoff_stat(xoff_stat), .spec_stat(spec_stat), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model
   logic [1:0] m_mode = 2'b00;
   bit m_spec = 0, m_cts = 0, m_park = 0, m_pres = 0, m_pstp = 0, m_xf = 0, m_sf = 0;
   logic [7:0] m_ch [4] = '{8'h00, 8'h00, 8'h00, 8'h00};

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_tx();
      return !m_park && !(m_cts && cts_n);
   endfunction

   task automatic check_outs(string req);
      check({req, " tx_enable"}, tx_enable, exp_tx());
      check("R6 xoff_stat", xoff_stat, m_xf);
      check("R7 spec_stat", spec_stat, m_sf);
      check("R6 irq", irq, rx_int_en && (m_xf || m_sf));
   endtask

   task automatic wr(logic [2:0] sel, logic [7:0] val, logic [7:0] lcr);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = val; lcr_in = lcr;
      @(posedge clk); #1;
      reg_wr = 1'b0; lcr_in = 8'h00;
      if (lcr == 8'hBF) begin
         if (sel == 3'd0) begin
            m_mode = val[1:0]; m_spec = val[5]; m_cts = val[7];
            if (val[1:0] != 2'b11) begin m_pres = 0; m_pstp = 0; end
            if (val[1:0] == 2'b00) m_park = 0;
         end else if (sel <= 3'd4) m_ch[sel-1] = val;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   // sends one byte; returns expected push, checks push and post-edge state
   task automatic send(logic [7:0] b, bit ack, string req);
      bit e0, e1, e2, e3, hr, hs, sp, push;
      e0 = (b == m_ch[0]); e1 = (b == m_ch[1]); e2 = (b == m_ch[2]); e3 = (b == m_ch[3]);
      case (m_mode)
         2'b01: begin hr = e0; hs = e2; end
         2'b10: begin hr = e1; hs = e3; end
         2'b11: begin hr = m_pres && e1; hs = m_pstp && e3; end
         default: begin hr = 0; hs = 0; end
      endcase
      sp = m_spec && e3;
      push = !(hr || hs) || sp;
      @(negedge clk);
      rx_byte = b; rx_valid = 1'b1; irq_ack = ack;
      #1 check({req, " rx_push"}, rx_push, push);
      @(posedge clk); #1;
      rx_valid = 1'b0; irq_ack = 1'b0;
      if (m_mode == 2'b00) m_park = 0;
      else if (hs) m_park = 1;
      else if (hr) m_park = 0;
      m_pres = (m_mode == 2'b11) && e0;
      m_pstp = (m_mode == 2'b11) && e2;
      m_xf = hs ? 1'b1 : (ack ? 1'b0 : m_xf);
      m_sf = sp ? 1'b1 : (ack ? 1'b0 : m_sf);
      check_outs(req);
   endtask

   task automatic ack_only();
      @(negedge clk); irq_ack = 1'b1;
      @(posedge clk); #1 irq_ack = 1'b0;
      m_xf = 0; m_sf = 0;
      check_outs("R10");
   endtask

   task automatic sweep(string req);
      for (int b = 0; b < 256; b++) send(8'(b), 1'b0, req);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      #1 rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1 tx_enable", tx_enable, 1);
      check("R1 xoff_stat", xoff_stat, 0);
      check("R1 spec_stat", spec_stat, 0);
      check("R1 irq", irq, 0);
      send(8'h00, 1'b0, "R1 off mode zero byte");

      // characters: resume A/B, stop A/B (stop B is stop A bit-reversed)
      wr(3'd1, 8'h11, 8'hBF);
      wr(3'd2, 8'h91, 8'hBF);
      wr(3'd3, 8'h13, 8'hBF);
      wr(3'd4, 8'hC8, 8'hBF);

      // R3 off mode sweep
      sweep("R3");

      // R4 single set A, R8 bit order
      wr(3'd0, 8'h01, 8'hBF);
      send(8'hC8, 1'b0, "R8 reversed stop A");
      check("R8 not parked", tx_enable, 1);
      send(8'h13, 1'b0, "R4 stop A");
      check("R4 parked", tx_enable, 0);
      send(8'h91, 1'b0, "R4 wrong set resume");
      check("R4 still parked", tx_enable, 0);
      send(8'h11, 1'b0, "R4 resume A");
      check("R4 resumed", tx_enable, 1);
      ack_only();
      sweep("R4");
      send(8'h11, 1'b0, "R4 resume A");

      // R4 single set B
      wr(3'd0, 8'h02, 8'hBF);
      ack_only();
      sweep("R4");
      send(8'h91, 1'b0, "R4 resume B");
      check("R4 resumed B", tx_enable, 1);

      // R5 pair mode
      wr(3'd0, 8'h03, 8'hBF);
      ack_only();
      send(8'hC8, 1'b0, "R5 B alone");
      send(8'h13, 1'b0, "R5 A");
      send(8'h55, 1'b0, "R5 break");
      send(8'hC8, 1'b0, "R5 interrupted pair");
      check("R5 interrupted no park", tx_enable, 1);
      send(8'hC8, 1'b0, "R5 reversed order 1");
      send(8'h13, 1'b0, "R5 reversed order 2");
      idle(3);
      send(8'hC8, 1'b0, "R5 pair across gap");
      check("R5 pair parks", tx_enable, 0);
      send(8'h91, 1'b0, "R5 resume B alone");
      check("R5 still parked", tx_enable, 0);
      send(8'h11, 1'b0, "R5 resume A");
      send(8'h91, 1'b0, "R5 resume pair");
      check("R5 pair resumes", tx_enable, 1);
      ack_only();
      sweep("R5");

      // R2 locked writes
      wr(3'd0, 8'h01, 8'hBF);
      send(8'h11, 1'b0, "R2 setup");
      wr(3'd3, 8'h55, 8'hBE);
      wr(3'd0, 8'h00, 8'h3F);
      send(8'h55, 1'b0, "R2 locked char write ignored");
      check("R2 no park on 55", tx_enable, 1);
      send(8'h13, 1'b0, "R2 old stop still active");
      check("R2 parked by old char", tx_enable, 0);
      send(8'h11, 1'b0, "R2 resume");
      ack_only();

      // R7 special detect, also a stop match in set B
      wr(3'd0, 8'h22, 8'hBF);
      send(8'hC8, 1'b0, "R7 special and stop");
      check("R7 pushed", spec_stat, 1);
      send(8'h91, 1'b0, "R7 resume");
      ack_only();
      wr(3'd0, 8'h21, 8'hBF);
      sweep("R7");
      send(8'h11, 1'b0, "R7 resume");

      // R10 ack colliding with detection
      send(8'h13, 1'b1, "R10 detect wins over ack");
      check("R10 flag kept", xoff_stat, 1);
      ack_only();
      check("R10 cleared", xoff_stat, 0);

      // R6 interrupt enable off
      rx_int_en = 1'b0;
      send(8'h11, 1'b0, "R6 resume");
      send(8'h13, 1'b0, "R6 stop masked irq");
      check("R6 irq masked", irq, 0);
      rx_int_en = 1'b1;
      #1 check("R6 irq unmasked", irq, 1);
      ack_only();

      // R11 mode off releases parked transmitter
      check("R11 parked before", tx_enable, 0);
      wr(3'd0, 8'h00, 8'hBF);
      idle(1);
      check("R11 released", tx_enable, 1);

      // R9 CTS gating
      for (int c = 0; c < 2; c++) begin
         cts_n = c[0];
         #1 check("R9 cts ignored", tx_enable, 1);
      end
      wr(3'd0, 8'h81, 8'hBF);
      for (int c = 0; c < 2; c++) begin
         cts_n = c[0];
         #1 check("R9 cts gated", tx_enable, exp_tx());
         check("R9 cts level", tx_enable, !c[0]);
      end
      cts_n = 1'b0;
      send(8'h13, 1'b0, "R9 parked with cts ready");
      check("R9 parked wins", tx_enable, 0);
      send(8'h11, 1'b0, "R9 resume");
      check("R9 resumed", tx_enable, 1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule